// File: doc/BRIEF.md
# Manchester Uplink Word Framer

This block is the transmit side of a contactless tag's uplink. It runs on the clock recovered from the reader's RF field and drives a single modulator-control line. In its standard read mode it walks a configured address range from a first address to a last address and fetches each 32-bit word from memory. It wraps each word into a 45-bit frame protected by even row and column parity and sends the frame Manchester-coded. A listen window goes in front of every word, so the reader can synchronise on it and ask for the receive mode.

The reader-side command logic can ask for a status pattern, acknowledge or not-acknowledge. The request is held until the current word has gone out. The block then sends the pattern and starts over at the first address of the range. A word marked read-protected is sent as all zeros unless a login is active. Two flags tell the downlink receiver when a listen window is on air and when it is in one of its modulator-on segments.

The sequencer has four states. S_LIW_A is the first of two listen windows in front of the first word. S_LIW is the single listen window in front of any word. S_WORD sends the frame. S_STATUS sends the ACK or NAK pattern. The transitions are:
- Reset goes to S_LIW_A.
- S_LIW_A goes to S_LIW when it ends.
- S_LIW goes to S_WORD when it ends, and the frame is latched at that point.
- S_WORD goes to S_STATUS when a request is pending.
- Otherwise S_WORD goes to S_LIW_A when the word was at the last address, and to S_LIW with the address incremented when it was not.
- S_STATUS always goes to S_LIW_A at the first address.

Top module: `tag_uplink_framer`

## Requirements
- R1: A frame holds 45 bits, with frame bit 0 sent first. Frame bits 9r to 9r+7 carry data bits 8r to 8r+7 (r = 0..3), and frame bit 9r+8 makes the count of ones in that row even.
- R2: Frame bits 36+c (c = 0..7) make the count of ones even across data bits c, 8+c, 16+c and 24+c. Frame bit 44 is always 0.
- R3: Each bit lasts two half-bits. mod_on equals the bit value in the first half and its inverse in the second half. A half-bit lasts HALF_SLOW clocks when fast_mode=0 and HALF_FAST clocks when fast_mode=1 (defaults 32 and 16).
- R4: A listen window consists of segments lasting 1, 1, 4, 2 and 2 half-bits, in that order. mod_on is 1 in the first segment and flips at each segment boundary.
- R5: Two listen windows come before the word at first_addr. Exactly one comes before every other word.
- R6: Words are sent at first_addr, first_addr+1, up to last_addr, and then the range starts again at first_addr. When first_addr equals last_addr, the one word repeats, with two listen windows before each copy.
- R7: When mem_rprot=1 and logged_in=0 while the frame is latched at the end of its listen window, all 45 frame bits are 0.
- R8: The ACK pattern consists of segments lasting 1, 1, 3, 1, 2, 1 and 1 half-bits, starting with mod_on=1 and flipping at each boundary.
- R9: The NAK pattern consists of segments lasting 1, 1, 3, 1, 3 and 1 half-bits, starting with mod_on=1 and flipping at each boundary.
- R10: A one-clock stat_req pulse is held until the current word ends, with stat_nak=1 selecting NAK and 0 selecting ACK. The pattern then follows that word in place of the next listen window, and transmission restarts with two listen windows and the word at first_addr.
- R11: liw_active is 1 exactly while a listen window is on air. liw_mod_seg is 1 exactly in listen-window segments where mod_on is 1.
- R12: While rst_n is low, and at the first clock after it rises, mod_on=1, liw_active=1 and mem_addr=first_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered RF clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_mode | input | 1 | 1 selects the short bit period |
| first_addr | input | AW | First address of the read range |
| last_addr | input | AW | Last address of the read range |
| mem_addr | output | AW | Address of the word being sent or about to be sent |
| mem_rdata | input | DW | Memory word at mem_addr |
| mem_rprot | input | 1 | Word at mem_addr is read-protected |
| logged_in | input | 1 | Login is active |
| stat_req | input | 1 | Request a status pattern |
| stat_nak | input | 1 | With stat_req: 1 for NAK, 0 for ACK |
| mod_on | output | 1 | Modulator control level |
| liw_active | output | 1 | A listen window is on air |
| liw_mod_seg | output | 1 | In a modulator-on segment of a listen window |

## Verification
The properties check on every cycle that the modulator level, the listen-window flag and the address move only on half-bit boundaries. They also check that every bit of a word flips mid-bit, that the on-segment flag is never raised outside a listen window or with the modulator off, and that each address step goes either to the next address or back to the first. Only the bench's scenarios can show the rest: the exact segment shapes of the three patterns, the parity content of each frame, the range order with its double listen window at the wrap, the zeroed protected word, and the deferred status pattern followed by the restart.

// File: rtl/uplink_pkg.sv
package uplink_pkg;

    localparam int FRAME_BITS = 45;
    localparam int WORD_HALVES = 2 * FRAME_BITS;

    typedef enum logic [1:0] {
        S_LIW_A,
        S_LIW,
        S_WORD,
        S_STATUS
    } fsm_t;

    typedef enum logic [1:0] {
        PAT_LIW,
        PAT_ACK,
        PAT_NAK
    } pat_t;

endpackage

// File: rtl/half_timer.sv
module half_timer #(
    parameter int HALF_SLOW = 32,
    parameter int HALF_FAST = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_mode,
    output logic tick
);
    localparam int CW = $clog2(HALF_SLOW);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = fast_mode ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
        tick  = (cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pattern_rom.sv
module pattern_rom
    import uplink_pkg::*;
(
    input  pat_t       kind,
    input  logic [2:0] seg,
    output logic [2:0] len,
    output logic       last_seg
);
    always_comb begin
        len      = 3'd1;
        last_seg = 1'b0;
        unique case (kind)
            PAT_LIW: begin
                unique case (seg)
                    3'd2:    len = 3'd4;
                    3'd3:    len = 3'd2;
                    3'd4:    len = 3'd2;
                    default: len = 3'd1;
                endcase
                last_seg = (seg == 3'd4);
            end
            PAT_ACK: begin
                unique case (seg)
                    3'd2:    len = 3'd3;
                    3'd4:    len = 3'd2;
                    default: len = 3'd1;
                endcase
                last_seg = (seg == 3'd6);
            end
            PAT_NAK: begin
                unique case (seg)
                    3'd2:    len = 3'd3;
                    3'd4:    len = 3'd3;
                    default: len = 3'd1;
                endcase
                last_seg = (seg == 3'd5);
            end
            default: begin
                len      = 3'd1;
                last_seg = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/frame_builder.sv
module frame_builder
    import uplink_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]         data,
    input  logic                  blank,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int ROWS = 4;
    localparam int COLS = DW / ROWS;

    logic [DW-1:0] d;
    assign d = blank ? '0 : data;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign frame[r*(COLS+1) +: COLS] = d[r*COLS +: COLS];
        assign frame[r*(COLS+1) + COLS]  = ^d[r*COLS +: COLS];
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] col;
        for (genvar r = 0; r < ROWS; r++) begin : g_bit
            assign col[r] = d[r*COLS + c];
        end
        assign frame[ROWS*(COLS+1) + c] = ^col;
    end

    assign frame[FRAME_BITS-1] = 1'b0;
endmodule

// File: rtl/tag_uplink_framer.sv
module tag_uplink_framer
    import uplink_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 6,
    parameter int HALF_SLOW = 32,
    parameter int HALF_FAST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fast_mode,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rprot,
    input  logic          logged_in,
    input  logic          stat_req,
    input  logic          stat_nak,
    output logic          mod_on,
    output logic          liw_active,
    output logic          liw_mod_seg
);
    localparam int PW = $clog2(WORD_HALVES);

    fsm_t                  state, nxt_state;
    logic [PW-1:0]         pos;
    logic [2:0]            seg, seg_cnt;
    logic [FRAME_BITS-1:0] frame, frame_in;
    logic [AW-1:0]         addr;
    logic                  pend, pend_nak, stat_nak_r;
    logic                  tick;
    pat_t                  kind;
    logic [2:0]            seg_len;
    logic                  seg_last;
    logic                  seg_end, pat_end, word_end, item_end;

    half_timer #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) i_timer (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .tick(tick)
    );

    pattern_rom i_rom (
        .kind(kind), .seg(seg), .len(seg_len), .last_seg(seg_last)
    );

    frame_builder #(.DW(DW)) i_frame (
        .data(mem_rdata), .blank(mem_rprot && !logged_in), .frame(frame_in)
    );

    always_comb begin
        if (state == S_STATUS)
            kind = stat_nak_r ? PAT_NAK : PAT_ACK;
        else
            kind = PAT_LIW;
        seg_end  = tick && (state != S_WORD) && (seg_cnt == seg_len - 3'd1);
        pat_end  = seg_end && seg_last;
        word_end = tick && (state == S_WORD) && (pos == PW'(WORD_HALVES - 1));
        item_end = pat_end || word_end;
    end

    always_comb begin
        nxt_state = state;
        if (item_end) begin
            unique case (state)
                S_LIW_A:  nxt_state = S_LIW;
                S_LIW:    nxt_state = S_WORD;
                S_WORD:   nxt_state = pend ? S_STATUS
                                           : (addr == last_addr) ? S_LIW_A : S_LIW;
                S_STATUS: nxt_state = S_LIW_A;
                default:  nxt_state = S_LIW_A;
            endcase
        end
    end

    // state register and sequencing data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_LIW_A;
            pos        <= '0;
            seg        <= '0;
            seg_cnt    <= '0;
            frame      <= '0;
            addr       <= first_addr;
            pend       <= 1'b0;
            pend_nak   <= 1'b0;
            stat_nak_r <= 1'b0;
        end else begin
            state <= nxt_state;
            if (item_end) begin
                pos     <= '0;
                seg     <= '0;
                seg_cnt <= '0;
            end else if (tick) begin
                if (state == S_WORD)
                    pos <= pos + 1'b1;
                else if (seg_end) begin
                    seg     <= seg + 3'd1;
                    seg_cnt <= '0;
                end else
                    seg_cnt <= seg_cnt + 3'd1;
            end
            if (item_end && state == S_LIW)
                frame <= frame_in;
            if (word_end && !pend) begin
                if (addr == last_addr)
                    addr <= first_addr;
                else
                    addr <= addr + 1'b1;
            end
            if (pat_end && state == S_STATUS)
                addr <= first_addr;
            if (word_end && pend) begin
                pend       <= 1'b0;
                stat_nak_r <= pend_nak;
            end
            if (stat_req) begin
                pend     <= 1'b1;
                pend_nak <= stat_nak;
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr    = addr;
        liw_active  = 1'b0;
        liw_mod_seg = 1'b0;
        mod_on      = 1'b0;
        unique case (state)
            S_LIW_A, S_LIW: begin
                liw_active  = 1'b1;
                mod_on      = ~seg[0];
                liw_mod_seg = ~seg[0];
            end
            S_STATUS: mod_on = ~seg[0];
            S_WORD:   mod_on = frame[pos[PW-1:1]] ^ pos[0];
            default:  mod_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/uplink_framer_chk.sv
module uplink_framer_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          mod_on,
    input logic          liw_active,
    input logic          liw_mod_seg,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] first_addr,
    input logic          in_word,
    input logic          half_sel
);
    // R11: the on-segment flag implies an active listen window with the modulator on
    a_r11_flag_inside_liw: assert property (@(posedge clk) disable iff (!rst_n)
        liw_mod_seg |-> (liw_active && mod_on));

    // R3, R4: levels change only on half-bit boundaries
    a_r3_half_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(mod_on) && $stable(liw_active) && $stable(mem_addr)));

    // R3: the second half of every data bit is the inverse of the first
    a_r3_mid_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (in_word && tick && !half_sel) |=> (mod_on != $past(mod_on)));

    // R6: the address only steps to the next one or back to the first
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> ((mem_addr == first_addr) ||
                                (mem_addr == AW'($past(mem_addr) + 1'b1))));
endmodule

bind tag_uplink_framer uplink_framer_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mod_on(mod_on),
    .liw_active(liw_active), .liw_mod_seg(liw_mod_seg),
    .mem_addr(mem_addr), .first_addr(first_addr),
    .in_word(state == uplink_pkg::S_WORD), .half_sel(pos[0])
);

// File: tb/test_tag_uplink_framer.sv
`timescale 1ns/1ps
module test_tag_uplink_framer;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int HS = 32;
    localparam int HF = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fast_mode = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          mem_rprot;
    logic          logged_in = 1'b0;
    logic          stat_req = 1'b0, stat_nak = 1'b0;
    logic          mod_on, liw_active, liw_mod_seg;

    int n_chk = 0, n_bad = 0, hl = HS;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return 32'h9E37_79B9 ^ ({26'b0, a} * 32'h01F3_0A57);
    endfunction

    assign mem_rdata = word_of(mem_addr);
    assign mem_rprot = (mem_addr == 6'd8);

    tag_uplink_framer #(.DW(DW), .AW(AW), .HALF_SLOW(HS), .HALF_FAST(HF)) i_tag_uplink_framer (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .first_addr(first_addr),
        .last_addr(last_addr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_rprot(mem_rprot), .logged_in(logged_in), .stat_req(stat_req),
        .stat_nak(stat_nak), .mod_on(mod_on), .liw_active(liw_active),
        .liw_mod_seg(liw_mod_seg)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic start(input logic fm, input int fa, input int la);
        rst_n = 1'b0;
        fast_mode = fm;
        first_addr = AW'(fa);
        last_addr = AW'(la);
        hl = fm ? HF : HS;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(mod_on == 1'b1, "R12 mod_on", int'(mod_on), 1);
        chk(liw_active == 1'b1, "R12 liw_active", int'(liw_active), 1);
        chk(mem_addr == AW'(fa), "R12 mem_addr", int'(mem_addr), fa);
        repeat (hl / 2) @(negedge clk);
    endtask

    // lens: one nibble per segment, lowest nibble first, in half-bits
    task automatic exp_pat(input logic [31:0] lens, input int nseg, input logic is_liw,
                           input string tag);
        for (int s = 0; s < nseg; s++) begin
            logic lvl;
            lvl = (s % 2 == 0);
            for (int k = 0; k < int'(lens[4*s +: 4]); k++) begin
                chk(mod_on == lvl, tag, int'(mod_on), int'(lvl));
                chk(liw_active == is_liw, "R11 liw_active", int'(liw_active), int'(is_liw));
                chk(liw_mod_seg == (is_liw && lvl), "R11 liw_mod_seg",
                    int'(liw_mod_seg), int'(is_liw && lvl));
                repeat (hl) @(negedge clk);
            end
        end
    endtask

    task automatic exp_liw(input string tag);
        exp_pat(32'h0002_2411, 5, 1'b1, tag);
    endtask

    task automatic exp_word(input int a, input logic zeroed, input int pulse_h,
                            input logic pulse_nak);
        logic [DW-1:0] d;
        logic [44:0]   f;
        d = zeroed ? '0 : word_of(AW'(a));
        for (int r = 0; r < 4; r++) begin
            logic p;
            p = 1'b0;
            for (int c = 0; c < 8; c++) begin
                f[r*9 + c] = d[r*8 + c];
                p = p ^ d[r*8 + c];
            end
            f[r*9 + 8] = p;
        end
        for (int c = 0; c < 8; c++)
            f[36 + c] = d[c] ^ d[8 + c] ^ d[16 + c] ^ d[24 + c];
        f[44] = 1'b0;
        chk(mem_addr == AW'(a), "R6 word address", int'(mem_addr), a);
        for (int h = 0; h < 90; h++) begin
            logic  e;
            string tg;
            e = f[h / 2] ^ (h % 2 == 1);
            if (zeroed) tg = "R7 zeroed frame";
            else if (h % 2 == 1) tg = "R3 second half";
            else if (h / 2 >= 36) tg = "R2 column/stop";
            else tg = "R1 row data/parity";
            chk(mod_on == e, tg, int'(mod_on), int'(e));
            chk(liw_active == 1'b0, "R11 liw off in word", int'(liw_active), 0);
            if (h == pulse_h) begin
                stat_req = 1'b1;
                stat_nak = pulse_nak;
                @(negedge clk);
                stat_req = 1'b0;
                repeat (hl - 1) @(negedge clk);
            end else
                repeat (hl) @(negedge clk);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog expired: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        // slow option, range 3..4: R3 R4 R5 R6
        start(1'b0, 3, 4);
        exp_liw("R5 first of two");
        exp_liw("R4 listen window");
        exp_word(3, 1'b0, -1, 1'b0);
        exp_liw("R5 single before next");
        exp_word(4, 1'b0, -1, 1'b0);
        exp_liw("R6 wrap first");
        exp_liw("R6 wrap second");
        exp_word(3, 1'b0, -1, 1'b0);

        // fast option, single word range: R6 R3
        start(1'b1, 5, 5);
        exp_liw("R5 fast");
        exp_liw("R4 fast");
        exp_word(5, 1'b0, -1, 1'b0);
        exp_liw("R6 repeat first");
        exp_liw("R6 repeat second");
        exp_word(5, 1'b0, -1, 1'b0);

        // protected word at 8: R7
        logged_in = 1'b0;
        start(1'b1, 7, 9);
        exp_liw("R5");
        exp_liw("R4");
        exp_word(7, 1'b0, -1, 1'b0);
        exp_liw("R4");
        exp_word(8, 1'b1, -1, 1'b0);
        exp_liw("R4");
        exp_word(9, 1'b0, -1, 1'b0);
        exp_liw("R6 wrap");
        exp_liw("R6 wrap");
        logged_in = 1'b1;
        exp_word(7, 1'b0, -1, 1'b0);
        exp_liw("R4");
        exp_word(8, 1'b0, -1, 1'b0);
        logged_in = 1'b0;

        // status patterns: R8 R9 R10
        start(1'b1, 2, 6);
        exp_liw("R5");
        exp_liw("R4");
        exp_word(2, 1'b0, 20, 1'b0);
        exp_pat(32'h0112_1311, 7, 1'b0, "R8 ACK");
        exp_liw("R10 restart first");
        exp_liw("R10 restart second");
        exp_word(2, 1'b0, -1, 1'b0);
        exp_liw("R4");
        exp_word(3, 1'b0, 70, 1'b1);
        exp_pat(32'h0013_1311, 6, 1'b0, "R9 NAK");
        exp_liw("R10 restart first");
        exp_liw("R10 restart second");
        exp_word(2, 1'b0, -1, 1'b0);

        summary();
        $finish;
    end
endmodule